// File: doc/BRIEF.md
# Complementary PWM Pair Timer

This block is a 16-bit timer that drives two PWM pins. Its counter either runs over the whole 16-bit range or between a programmed start value and end value. In edge mode it only counts up and wraps. In center mode it counts up and then down. The two pins can run independently, follow one shared compare value, or act as a complementary pair. In the complementary case a programmable deadtime gap separates the two active phases.

Around the waveform sit the safety and control features. Four fault inputs, each with its own enable, force both pins to their inactive level. Each pin has its own polarity bit, and each pin can be overridden directly. Sticky flags record counter overflow, compare hits and faults. A single-cycle trigger pulse fires when the counter passes a chosen value.

Top module: `pwm_pair_timer`

## Requirements
- R1: With `cntEn` low the counter is loaded with the start value on every clock and the direction is set to up. With `cntEn` high and `centerMode` low it steps up by one per clock and returns to the start value on the clock after it reaches or passes the end value. `fullRange` high replaces the start value with 0 and the end value with 0xFFFF. Reset clears the counter to 0.
- R2: With `centerMode` high the counter steps up to the end value. On the next clock it steps down by one. It then steps down to the start value and on the next clock steps up by one. The direction flag is still "up" on the clock where the end value shows and still "down" on the clock where the start value shows after a down phase.
- R3: Edge mode. A channel's internal level goes high on the clock after the counter equals the start value. It goes low on the clock after the counter equals that channel's compare value, and the compare wins if both hold. A pin shows this level one further clock later. The level only changes while `cntEn` is high.
- R4: Center mode. A channel's internal level goes high on the clock after the counter equals its compare value while counting up. It goes low on the clock after such a match while counting down. There is the same one-clock pin stage.
- R5: `pairMode` encoding: 0 and 3 mean independent channels; 1 means both pins follow channel 0; 2 means complementary, with pin 1 following the inverse of channel 0.
- R6: In complementary mode a pin that should become active waits `deadTime` extra clocks before it goes active. Going inactive is never delayed. Once the mode has been complementary for a clock, both pins are never logically active together. Outside complementary mode the deadtime is zero.
- R7: A `pinPolarity` bit of 1 makes that pin active-low; the inactive level of a pin equals its polarity bit.
- R8: Any fault input whose `faultEn` bit is set forces both pins to their inactive level in the same cycle and sets `faultFlag` on the next clock. The pins stay forced until no enabled fault is present and a clear (`flagClr[3]`) has removed the flag. A clear is ignored while an enabled fault is present, and a fault on a disabled input has no effect.
- R9: A set `ovrEn` bit replaces that pin's logical level with the `ovrVal` bit, and polarity is then applied. A fault takes precedence over the override.
- R10: `ovfFlag` is set on the clock after the counter is at or past the end value while counting up and enabled. `cmpFlag[c]` is set on the clock after the counter equals compare value c while enabled. Clear bits are `flagClr[0]` for overflow, `flagClr[1]` and `flagClr[2]` for the two compare flags, and `flagClr[3]` for the fault flag. A set in the same clock takes precedence over a clear. Reset clears all flags.
- R11: `trigOut` is high for the clock after the counter equals `trigVal` while `cntEn` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Counter run enable |
| centerMode | input | 1 | 1: up-down count with center-aligned PWM |
| fullRange | input | 1 | 1: count over 0..0xFFFF |
| cntStart | input | 16 | Start (lowest) counter value |
| cntEnd | input | 16 | End (highest) counter value |
| cmpVal0 | input | 16 | Compare value of channel 0 |
| cmpVal1 | input | 16 | Compare value of channel 1 |
| pairMode | input | 2 | Channel pairing mode |
| deadTime | input | 6 | Deadtime in clocks for complementary mode |
| pinPolarity | input | 2 | Per-pin active-low select |
| ovrEn | input | 2 | Per-pin software override enable |
| ovrVal | input | 2 | Per-pin override logical level |
| faultIn | input | 4 | Fault inputs |
| faultEn | input | 4 | Per-input fault enable |
| trigVal | input | 16 | Counter value that fires the trigger |
| flagClr | input | 4 | Flag clear strobes |
| pwmOut | output | 2 | PWM pins |
| count | output | 16 | Counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 2 | Sticky compare flags |
| faultFlag | output | 1 | Sticky fault flag |
| trigOut | output | 1 | Trigger pulse |

## Verification
Some properties are checked on every cycle by assertions:
- the counter's step rule while it runs, and its reload while it is stopped;
- the complementary pins never being active at the same time;
- the fault flag setting and holding while an enabled fault is present;
- the overflow flag following the end-of-range point.

The exact pin waveforms for each compare value, deadtime, polarity and override setting, and the clear-then-release order after a fault, are shown only by the bench's sweeps. In those sweeps every output is compared each cycle against a cycle model built from the requirements.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;

  typedef enum logic [1:0] {
    PAIR_INDEP  = 2'd0,
    PAIR_EQUAL  = 2'd1,
    PAIR_COMPL  = 2'd2,
    PAIR_INDEP2 = 2'd3
  } pairMode_e;

  // Strobes from the counter control to the output datapath
  typedef struct packed {
    logic       dirUp;   // current count direction
    logic       atStart; // counter equals start value, running
    logic [1:0] cmpHit;  // counter equals compare value, running
  } cntStrobe_t;

endpackage

// File: rtl/pwm_pair_ctrl.sv
`timescale 1ns/1ps
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cntEn,
  input  logic                       centerMode,
  input  logic                       fullRange,
  input  logic [CNT_W-1:0]           cntStart,
  input  logic [CNT_W-1:0]           cntEnd,
  input  logic [1:0][CNT_W-1:0]      cmpVal,
  input  logic [CNT_W-1:0]           trigVal,
  input  logic                       ovfClr,
  input  logic [1:0]                 cmpClr,
  output cntStrobe_t                 strobe,
  output logic [CNT_W-1:0]           count,
  output logic                       ovfFlag,
  output logic [1:0]                 cmpFlag,
  output logic                       trigOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             dirUp;
  logic [CNT_W-1:0] effStart;
  logic [CNT_W-1:0] effEnd;
  logic             pastEnd;
  logic             pastStart;
  logic             ovfEvent;

  assign effStart  = fullRange ? '0 : cntStart;
  assign effEnd    = fullRange ? CNT_MAX : cntEnd;
  assign pastEnd   = cnt >= effEnd;
  assign pastStart = cnt <= effStart;
  assign ovfEvent  = cntEn && dirUp && pastEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (!cntEn) begin
      cnt   <= effStart;
      dirUp <= 1'b1;
    end else if (!centerMode) begin
      cnt   <= pastEnd ? effStart : cnt + CNT_ONE;
      dirUp <= 1'b1;
    end else if (dirUp) begin
      if (pastEnd) begin
        cnt   <= cnt - CNT_ONE;
        dirUp <= 1'b0;
      end else begin
        cnt   <= cnt + CNT_ONE;
      end
    end else begin
      if (pastStart) begin
        cnt   <= cnt + CNT_ONE;
        dirUp <= 1'b1;
      end else begin
        cnt   <= cnt - CNT_ONE;
      end
    end
  end

  assign count          = cnt;
  assign strobe.dirUp   = dirUp;
  assign strobe.atStart = cntEn && (cnt == effStart);

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    assign strobe.cmpHit[c] = cntEn && (cnt == cmpVal[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cmpFlag[c] <= 1'b0;
      else if (strobe.cmpHit[c])  cmpFlag[c] <= 1'b1;
      else if (cmpClr[c])         cmpFlag[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      trigOut <= 1'b0;
    end else begin
      if (ovfEvent)    ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
      trigOut <= cntEn && (cnt == trigVal);
    end
  end

  // R1: a stopped counter reloads the start value
  a_r1_stopped_reload: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> count == $past(effStart));

  // R2: a running counter moves by one or returns to the start value
  a_r2_step_rule: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> (count == $past(count) + CNT_ONE) || (count == $past(count) - CNT_ONE)
              || (count == $past(effStart)));

  // R10: the end-of-range point sets the overflow flag
  a_r10_ovf_set: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> ovfFlag);

endmodule

// File: rtl/pwm_pair_deadtime.sv
`timescale 1ns/1ps
module pwm_pair_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tgt,
  input  logic [DT_W-1:0] dly,
  output logic            act
);

  localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

  logic [DT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act     <= 1'b0;
      waitCnt <= '0;
    end else if (!tgt) begin
      act     <= 1'b0;
      waitCnt <= '0;
    end else if (!act) begin
      if (waitCnt >= dly) act <= 1'b1;
      else                waitCnt <= waitCnt + DT_ONE;
    end
  end

endmodule

// File: rtl/pwm_pair_out.sv
`timescale 1ns/1ps
module pwm_pair_out
  import pwm_pair_pkg::*;
#(
  parameter int DT_W  = 6,
  parameter int N_FLT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic             centerMode,
  input  logic [1:0]       pairMode,
  input  logic [DT_W-1:0]  deadTime,
  input  logic [1:0]       pinPolarity,
  input  logic [1:0]       ovrEn,
  input  logic [1:0]       ovrVal,
  input  logic [N_FLT-1:0] faultIn,
  input  logic [N_FLT-1:0] faultEn,
  input  logic             faultClr,
  output logic [1:0]       pwmOut,
  output logic             faultFlag
);

  pairMode_e       pm;
  logic [1:0]      raw;
  logic [1:0]      tgt;
  logic [1:0]      act;
  logic [DT_W-1:0] dtEff;
  logic            faultNow;
  logic            blocked;

  assign pm = pairMode_e'(pairMode);

  for (genvar c = 0; c < 2; c++) begin : g_raw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        raw[c] <= 1'b0;
      end else if (centerMode) begin
        if (strobe.cmpHit[c]) raw[c] <= strobe.dirUp;
      end else begin
        if (strobe.cmpHit[c])    raw[c] <= 1'b0;
        else if (strobe.atStart) raw[c] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (pm)
      PAIR_EQUAL: tgt = {raw[0], raw[0]};
      PAIR_COMPL: tgt = {~raw[0], raw[0]};
      default:    tgt = raw;
    endcase
    dtEff = (pm == PAIR_COMPL) ? deadTime : '0;
  end

  for (genvar c = 0; c < 2; c++) begin : g_dt
    pwm_pair_deadtime #(.DT_W(DT_W)) u_dt (
      .clk  (clk),
      .rstN (rstN),
      .tgt  (tgt[c]),
      .dly  (dtEff),
      .act  (act[c])
    );
  end

  assign faultNow = |(faultIn & faultEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultFlag <= 1'b0;
    else if (faultNow) faultFlag <= 1'b1;
    else if (faultClr) faultFlag <= 1'b0;
  end

  assign blocked = faultNow || faultFlag;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      if (blocked)       pwmOut[c] = pinPolarity[c];
      else if (ovrEn[c]) pwmOut[c] = ovrVal[c] ^ pinPolarity[c];
      else               pwmOut[c] = act[c] ^ pinPolarity[c];
    end
  end

  // R6: complementary pins are never both active
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    $past(pm) == PAIR_COMPL |-> !(act[0] && act[1]));

  // R8: an enabled fault sets the flag
  a_r8_fault_set: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> faultFlag);

  // R8: the flag cannot be cleared while the fault persists
  a_r8_fault_hold: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && faultNow) |=> faultFlag);

endmodule

// File: rtl/pwm_pair_timer.sv
`timescale 1ns/1ps
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 6,
  parameter int N_FLT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             centerMode,
  input  logic             fullRange,
  input  logic [CNT_W-1:0] cntStart,
  input  logic [CNT_W-1:0] cntEnd,
  input  logic [CNT_W-1:0] cmpVal0,
  input  logic [CNT_W-1:0] cmpVal1,
  input  logic [1:0]       pairMode,
  input  logic [DT_W-1:0]  deadTime,
  input  logic [1:0]       pinPolarity,
  input  logic [1:0]       ovrEn,
  input  logic [1:0]       ovrVal,
  input  logic [N_FLT-1:0] faultIn,
  input  logic [N_FLT-1:0] faultEn,
  input  logic [CNT_W-1:0] trigVal,
  input  logic [3:0]       flagClr,
  output logic [1:0]       pwmOut,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic [1:0]       cmpFlag,
  output logic             faultFlag,
  output logic             trigOut
);

  cntStrobe_t              strobe;
  logic [1:0][CNT_W-1:0]   cmpVec;

  assign cmpVec = {cmpVal1, cmpVal0};

  pwm_pair_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntEn      (cntEn),
    .centerMode (centerMode),
    .fullRange  (fullRange),
    .cntStart   (cntStart),
    .cntEnd     (cntEnd),
    .cmpVal     (cmpVec),
    .trigVal    (trigVal),
    .ovfClr     (flagClr[0]),
    .cmpClr     (flagClr[2:1]),
    .strobe     (strobe),
    .count      (count),
    .ovfFlag    (ovfFlag),
    .cmpFlag    (cmpFlag),
    .trigOut    (trigOut)
  );

  pwm_pair_out #(.DT_W(DT_W), .N_FLT(N_FLT)) u_out (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .centerMode  (centerMode),
    .pairMode    (pairMode),
    .deadTime    (deadTime),
    .pinPolarity (pinPolarity),
    .ovrEn       (ovrEn),
    .ovrVal      (ovrVal),
    .faultIn     (faultIn),
    .faultEn     (faultEn),
    .faultClr    (flagClr[3]),
    .pwmOut      (pwmOut),
    .faultFlag   (faultFlag)
  );

endmodule

// File: tb/pwm_pair_timer_tb.sv
`timescale 1ns/1ps
module pwm_pair_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic        centerMode = 1'b0;
  logic        fullRange = 1'b0;
  logic [15:0] cntStart = '0;
  logic [15:0] cntEnd = '0;
  logic [15:0] cmpVal0 = '0;
  logic [15:0] cmpVal1 = '0;
  logic [1:0]  pairMode = '0;
  logic [5:0]  deadTime = '0;
  logic [1:0]  pinPolarity = '0;
  logic [1:0]  ovrEn = '0;
  logic [1:0]  ovrVal = '0;
  logic [3:0]  faultIn = '0;
  logic [3:0]  faultEn = '0;
  logic [15:0] trigVal = '0;
  logic [3:0]  flagClr = '0;
  logic [1:0]  pwmOut;
  logic [15:0] count;
  logic        ovfFlag;
  logic [1:0]  cmpFlag;
  logic        faultFlag;
  logic        trigOut;

  always #2.5 clk = ~clk;

  pwm_pair_timer dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .centerMode(centerMode),
    .fullRange(fullRange), .cntStart(cntStart), .cntEnd(cntEnd),
    .cmpVal0(cmpVal0), .cmpVal1(cmpVal1), .pairMode(pairMode),
    .deadTime(deadTime), .pinPolarity(pinPolarity), .ovrEn(ovrEn),
    .ovrVal(ovrVal), .faultIn(faultIn), .faultEn(faultEn),
    .trigVal(trigVal), .flagClr(flagClr), .pwmOut(pwmOut), .count(count),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag), .faultFlag(faultFlag),
    .trigOut(trigOut)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // Cycle model built from the requirements
  logic [15:0] mCnt = '0;
  logic        mDir = 1'b1;
  logic [1:0]  mRaw = '0;
  logic [1:0]  mAct = '0;
  logic [5:0]  mWt0 = '0;
  logic [5:0]  mWt1 = '0;
  logic        mOvf = 1'b0;
  logic [1:0]  mCmpF = '0;
  logic        mFltF = 1'b0;
  logic        mTrig = 1'b0;

  task automatic chk(string t, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, actual, expected);
    end
  endtask

  task automatic stepModel();
    logic [15:0] s;
    logic [15:0] e;
    logic [15:0] nCnt;
    logic        nDir;
    logic [1:0]  nRaw;
    logic [1:0]  tgt;
    logic [1:0]  nAct;
    logic [5:0]  dt;
    logic [5:0]  wt [2];
    logic [15:0] cv [2];
    logic        hit;
    s = fullRange ? 16'h0000 : cntStart;
    e = fullRange ? 16'hFFFF : cntEnd;
    cv[0] = cmpVal0;
    cv[1] = cmpVal1;
    wt[0] = mWt0;
    wt[1] = mWt1;
    nDir = mDir;
    // R1/R2 counter sequence
    if (!cntEn) begin
      nCnt = s; nDir = 1'b1;
    end else if (!centerMode) begin
      nCnt = (mCnt >= e) ? s : mCnt + 16'd1; nDir = 1'b1;
    end else if (mDir) begin
      if (mCnt >= e) begin nCnt = mCnt - 16'd1; nDir = 1'b0; end
      else nCnt = mCnt + 16'd1;
    end else begin
      if (mCnt <= s) begin nCnt = mCnt + 16'd1; nDir = 1'b1; end
      else nCnt = mCnt - 16'd1;
    end
    // R3/R4 channel levels
    nRaw = mRaw;
    for (int c = 0; c < 2; c++) begin
      hit = cntEn && (mCnt == cv[c]);
      if (centerMode) begin
        if (hit) nRaw[c] = mDir;
      end else if (hit) nRaw[c] = 1'b0;
      else if (cntEn && mCnt == s) nRaw[c] = 1'b1;
    end
    // R5/R6 pairing and deadtime
    case (pairMode)
      2'd1:    tgt = {mRaw[0], mRaw[0]};
      2'd2:    tgt = {~mRaw[0], mRaw[0]};
      default: tgt = mRaw;
    endcase
    dt = (pairMode == 2'd2) ? deadTime : 6'd0;
    nAct = mAct;
    for (int c = 0; c < 2; c++) begin
      if (!tgt[c]) begin
        nAct[c] = 1'b0; wt[c] = '0;
      end else if (!mAct[c]) begin
        if (wt[c] >= dt) nAct[c] = 1'b1;
        else wt[c] = wt[c] + 6'd1;
      end
    end
    // R10/R8/R11 flags and trigger
    if (cntEn && mDir && mCnt >= e) mOvf = 1'b1;
    else if (flagClr[0]) mOvf = 1'b0;
    for (int c = 0; c < 2; c++) begin
      if (cntEn && mCnt == cv[c]) mCmpF[c] = 1'b1;
      else if (flagClr[1+c]) mCmpF[c] = 1'b0;
    end
    if (|(faultIn & faultEn)) mFltF = 1'b1;
    else if (flagClr[3]) mFltF = 1'b0;
    mTrig = cntEn && (mCnt == trigVal);
    mCnt = nCnt;
    mDir = nDir;
    mRaw = nRaw;
    mAct = nAct;
    mWt0 = wt[0];
    mWt1 = wt[1];
  endtask

  task automatic compareAll();
    logic [1:0] expPin;
    logic       blocked;
    blocked = (|(faultIn & faultEn)) || mFltF;
    for (int c = 0; c < 2; c++) begin
      if (blocked)       expPin[c] = pinPolarity[c];
      else if (ovrEn[c]) expPin[c] = ovrVal[c] ^ pinPolarity[c];
      else               expPin[c] = mAct[c] ^ pinPolarity[c];
    end
    chk(centerMode ? "R2 count" : "R1 count", count, mCnt);
    chk($sformatf("%s pins", tag), pwmOut, expPin);
    chk("R10 flags", {ovfFlag, cmpFlag}, {mOvf, mCmpF});
    chk("R8 fault flag", faultFlag, mFltF);
    chk("R11 trigger", trigOut, mTrig);
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      stepModel();
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll();                        // reset state, R1 and R10
    cntStart = 16'd2; cntEnd = 16'd9; trigVal = 16'd5;
    run(4);                              // R1: stopped counter holds start
    cntEn = 1'b1;
    tag = "R3";
    for (int v = 0; v < 12; v++) begin   // R3 edge sweep
      cmpVal0 = 16'(v); cmpVal1 = 16'(11 - v);
      run(20);
    end
    tag = "R1";                          // R1 full-range wrap
    fullRange = 1'b1; cmpVal0 = 16'h8000; cmpVal1 = 16'hFFFF; trigVal = 16'hFFFE;
    run(66000);
    fullRange = 1'b0; trigVal = 16'd5;
    tag = "R4"; centerMode = 1'b1;       // R2/R4 center sweep
    for (int v = 0; v < 12; v++) begin
      cmpVal0 = 16'(v); cmpVal1 = 16'(11 - v);
      run(30);
    end
    tag = "R5"; centerMode = 1'b0; cmpVal0 = 16'd5; cmpVal1 = 16'd8;
    pairMode = 2'd1; run(40);
    pairMode = 2'd3; run(40);
    pairMode = 2'd0; run(20);
    tag = "R6"; pairMode = 2'd2; cmpVal0 = 16'd6;
    for (int d = 0; d < 6; d++) begin
      for (int m = 0; m < 2; m++) begin
        deadTime = 6'(d); centerMode = m[0];
        run(40);
      end
    end
    tag = "R7"; deadTime = 6'd2; centerMode = 1'b0;
    for (int p = 0; p < 4; p++) begin
      pinPolarity = 2'(p); run(30);
    end
    tag = "R9";
    ovrEn = 2'b01; ovrVal = 2'b01; run(20);
    ovrEn = 2'b11; ovrVal = 2'b10; run(20);
    ovrEn = 2'b00; run(10);
    tag = "R8"; faultEn = 4'b0100;
    faultIn = 4'b0001; run(10);          // disabled input: no effect
    faultIn = 4'b0100; run(5);
    ovrEn = 2'b11; ovrVal = 2'b11; run(3);
    flagClr = 4'b1000; run(1); flagClr = '0;   // clear while active: ignored
    faultIn = 4'b0000; run(5);           // still forced by the flag
    ovrEn = 2'b00;
    flagClr = 4'b1000; run(1); flagClr = '0;
    run(20);
    tag = "R10"; pinPolarity = 2'b00;
    flagClr = 4'b0001; run(2); flagClr = '0; run(15);
    flagClr = 4'b0110; run(12); flagClr = '0; run(15);
    tag = "R1"; cntEn = 1'b0; run(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule